// File: doc/BRIEF.md
# Untrusted Instruction Fetch Unit

This unit supplies 32-bit RISC-V instruction words to an execution pipeline from either of two sources. Trusted code comes from a preloaded program ROM. Untrusted code lives in ordinary writable data memory. For each accepted request, a select input chooses the source.

An untrusted fetch goes through several gates. It passes only when the pc is word aligned and lies at or above 64 KiB, and only while a global untrusted-execution enable is set. It issues a 64-bit read at the 8-byte-aligned address and, in parallel, asks an external page table for the permissions of the 4 KiB page that holds the pc. The unit then picks the addressed 32-bit half of the doubleword. It refuses the fetch when the page is not executable, and it refuses a system-call encoding, because only trusted code may make system calls. Each result carries a fault flag, a two-bit cause and a one-hot source tag.

The memory port, the permission port and the ROM port are valid/ready request channels, each paired with a response strobe. The unit holds one fetch in flight.

Top module: `ufetch_top`

## Requirements
- R1: An untrusted request whose pc has bit 1 or bit 0 set ends as a fault with cause 0. Cause encoding: 0 misaligned, 1 low address, 2 no execute right, 3 system call.
- R2: An untrusted fetch reads memory at the pc with its low three bits cleared. A pc with bit 2 clear returns data bits 31:0, and a pc with bit 2 set returns data bits 63:32.
- R3: An aligned untrusted pc below 2^16 (pc bits 47:16 all zero) faults with cause 1. Misalignment takes priority over the low-address fault.
- R4: An untrusted fetch queries the page whose number is pc bits 47:12. The permission response uses bit 0 for read, bit 1 for write and bit 2 for execute. If bit 2 is clear, the fetch faults with cause 2.
- R5: An aligned, non-low untrusted request made while untrusted_en is low faults with cause 2.
- R6: Every result raises exactly one of out_trusted and out_untrusted, and an idle cycle raises neither. Trusted requests use only the ROM port, and untrusted requests use only the memory and permission ports.
- R7: An executable untrusted word equal to 32'h0000_0073 faults with cause 3. A missing execute right takes priority over this fault.
- R8: out_valid is a one-cycle pulse. It appears one cycle after the later of the memory and permission responses, one cycle after the ROM response, or, for faults found at request time, one cycle after the request is accepted.
- R9: A request on the memory, permission or ROM port keeps valid high and its address stable until ready is seen.
- R10: A request rejected for misalignment, low address or a clear enable issues no memory and no permission request.
- R11: A faulting result drives out_instr to zero and is always tagged untrusted.
- R12: A trusted fetch returns the ROM word unchanged, whatever the state of untrusted_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| untrusted_en | input | 1 | Global permission to run untrusted code |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Unit can accept a request |
| req_untrusted | input | 1 | 1 selects the data-memory path, 0 selects the ROM |
| req_pc | input | 48 | Program counter (three 16-bit limbs) |
| rom_req_valid | output | 1 | ROM read request |
| rom_req_ready | input | 1 | ROM accepts request |
| rom_req_addr | output | 48 | ROM read address |
| rom_rsp_valid | input | 1 | ROM data strobe |
| rom_rsp_data | input | 32 | ROM instruction word |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 48 | 8-byte-aligned read address |
| mem_rsp_valid | input | 1 | Memory data strobe |
| mem_rsp_data | input | 64 | Doubleword read |
| perm_req_valid | output | 1 | Page permission query |
| perm_req_ready | input | 1 | Permission unit accepts query |
| perm_req_page | output | 36 | Page number queried |
| perm_rsp_valid | input | 1 | Permission strobe |
| perm_rsp_bits | input | 3 | Page rights (bit 2 execute) |
| out_valid | output | 1 | Result pulse |
| out_instr | output | 32 | Instruction word, zero on fault |
| out_fault | output | 1 | Fetch refused |
| out_cause | output | 2 | Fault cause |
| out_trusted | output | 1 | Result came from the ROM |
| out_untrusted | output | 1 | Result came from data memory |

## Verification
The memory doubleword and the page rights come back independently, and they can land in the same cycle or in either order. The bench runs all three orderings, adds ready back-pressure on each port, and checks that the result pulse comes exactly one cycle after the later strobe. A second collision is a non-executable page whose selected word is also a system call. Only the no-execute cause may appear in that case, and it is checked next to each fault taken alone.

// File: rtl/ufetch_pkg.sv
package ufetch_pkg;

    typedef enum logic [1:0] {
        CAUSE_MISALIGN = 2'd0,
        CAUSE_LOWADDR  = 2'd1,
        CAUSE_NOEXEC   = 2'd2,
        CAUSE_ECALL    = 2'd3
    } fault_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_UNTR  = 2'd1,
        ST_TRUST = 2'd2
    } fetch_state_e;

    localparam logic [31:0] SYSCALL_WORD = 32'h0000_0073;

    localparam int PORT_MEM  = 0;
    localparam int PORT_PERM = 1;
    localparam int PORT_ROM  = 2;
    localparam int NUM_PORTS = 3;

endpackage

// File: rtl/ufetch_precheck.sv
module ufetch_precheck
    import ufetch_pkg::*;
#(
    parameter int PC_W       = 48,
    parameter int GUARD_BITS = 16
) (
    input  logic [PC_W-1:0] pc,
    input  logic            untrusted_en,
    output logic            fault,
    output logic [1:0]      cause
);

    always_comb begin
        fault = 1'b1;
        cause = CAUSE_MISALIGN;
        if (pc[1:0] != 2'b00) begin
            cause = CAUSE_MISALIGN;
        end else if (pc[PC_W-1:GUARD_BITS] == '0) begin
            cause = CAUSE_LOWADDR;
        end else if (!untrusted_en) begin
            cause = CAUSE_NOEXEC;
        end else begin
            fault = 1'b0;
        end
    end

endmodule

// File: rtl/ufetch_resolve.sv
module ufetch_resolve
    import ufetch_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int INSTR_W  = 32,
    parameter int PERM_W   = 3,
    parameter int EXEC_BIT = 2,
    parameter int SEL_W    = 1
) (
    input  logic [DATA_W-1:0]  dword,
    input  logic [SEL_W-1:0]   lane_sel,
    input  logic [PERM_W-1:0]  perm,
    output logic [INSTR_W-1:0] word,
    output logic               fault,
    output logic [1:0]         cause
);

    localparam int LANES = DATA_W / INSTR_W;

    logic [INSTR_W-1:0] lane [LANES];
    logic [INSTR_W-1:0] picked;
    logic               unused_perm;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = dword[g*INSTR_W +: INSTR_W];
    end

    assign picked      = lane[lane_sel];
    assign unused_perm = ^perm;

    always_comb begin
        word  = '0;
        fault = 1'b1;
        cause = CAUSE_NOEXEC;
        if (!perm[EXEC_BIT]) begin
            cause = CAUSE_NOEXEC;
        end else if (picked == INSTR_W'(SYSCALL_WORD)) begin
            cause = CAUSE_ECALL;
        end else begin
            fault = 1'b0;
            word  = picked;
        end
    end

endmodule

// File: rtl/ufetch_req_slot.sv
module ufetch_req_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ready,
    output logic valid
);

    logic valid_d, valid_q;

    always_comb begin
        valid_d = valid_q;
        if (start) begin
            valid_d = 1'b1;
        end else if (valid_q && ready) begin
            valid_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= valid_d;
        end
    end

    assign valid = valid_q;

endmodule

// File: rtl/ufetch_top.sv
module ufetch_top
    import ufetch_pkg::*;
#(
    parameter int PC_W       = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int GUARD_BITS = 16,
    parameter int DATA_W     = 64,
    parameter int INSTR_W    = 32,
    parameter int PERM_W     = 3,
    parameter int EXEC_BIT   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     untrusted_en,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_untrusted,
    input  logic [PC_W-1:0]          req_pc,
    output logic                     rom_req_valid,
    input  logic                     rom_req_ready,
    output logic [PC_W-1:0]          rom_req_addr,
    input  logic                     rom_rsp_valid,
    input  logic [INSTR_W-1:0]       rom_rsp_data,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [PC_W-1:0]          mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [DATA_W-1:0]        mem_rsp_data,
    output logic                     perm_req_valid,
    input  logic                     perm_req_ready,
    output logic [PC_W-PAGE_SHIFT-1:0] perm_req_page,
    input  logic                     perm_rsp_valid,
    input  logic [PERM_W-1:0]        perm_rsp_bits,
    output logic                     out_valid,
    output logic [INSTR_W-1:0]       out_instr,
    output logic                     out_fault,
    output logic [1:0]               out_cause,
    output logic                     out_trusted,
    output logic                     out_untrusted
);

    localparam int PAGE_W       = PC_W - PAGE_SHIFT;
    localparam int BYTE_SEL_W   = $clog2(DATA_W / 8);
    localparam int INSTR_BYTE_W = $clog2(INSTR_W / 8);
    localparam int LANE_SEL_W   = BYTE_SEL_W - INSTR_BYTE_W;

    typedef struct packed {
        fetch_state_e       st;
        logic [PC_W-1:0]    pc;
        logic               mem_got;
        logic               perm_got;
        logic [DATA_W-1:0]  dword;
        logic [PERM_W-1:0]  perm;
        logic               out_valid;
        logic               out_fault;
        logic [1:0]         out_cause;
        logic               out_src_untr;
        logic [INSTR_W-1:0] out_word;
    } fetch_regs_t;

    fetch_regs_t r_d, r_q;

    logic                 pre_fault;
    logic [1:0]           pre_cause;
    logic [DATA_W-1:0]    dword_live;
    logic [PERM_W-1:0]    perm_live;
    logic                 mem_have, perm_have;
    logic [INSTR_W-1:0]   res_word;
    logic                 res_fault;
    logic [1:0]           res_cause;
    logic [NUM_PORTS-1:0] slot_start, slot_ready, slot_valid;

    ufetch_precheck #(
        .PC_W       (PC_W),
        .GUARD_BITS (GUARD_BITS)
    ) i_precheck (
        .pc           (req_pc),
        .untrusted_en (untrusted_en),
        .fault        (pre_fault),
        .cause        (pre_cause)
    );

    assign mem_have   = r_q.mem_got | mem_rsp_valid;
    assign perm_have  = r_q.perm_got | perm_rsp_valid;
    assign dword_live = r_q.mem_got ? r_q.dword : mem_rsp_data;
    assign perm_live  = r_q.perm_got ? r_q.perm : perm_rsp_bits;

    ufetch_resolve #(
        .DATA_W   (DATA_W),
        .INSTR_W  (INSTR_W),
        .PERM_W   (PERM_W),
        .EXEC_BIT (EXEC_BIT),
        .SEL_W    (LANE_SEL_W)
    ) i_resolve (
        .dword    (dword_live),
        .lane_sel (r_q.pc[BYTE_SEL_W-1:INSTR_BYTE_W]),
        .perm     (perm_live),
        .word     (res_word),
        .fault    (res_fault),
        .cause    (res_cause)
    );

    assign slot_ready[PORT_MEM]  = mem_req_ready;
    assign slot_ready[PORT_PERM] = perm_req_ready;
    assign slot_ready[PORT_ROM]  = rom_req_ready;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_slot
        ufetch_req_slot i_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .start (slot_start[g]),
            .ready (slot_ready[g]),
            .valid (slot_valid[g])
        );
    end

    always_comb begin
        r_d           = r_q;
        r_d.out_valid = 1'b0;
        slot_start    = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.pc = req_pc;
                    if (!req_untrusted) begin
                        r_d.st               = ST_TRUST;
                        slot_start[PORT_ROM] = 1'b1;
                    end else if (pre_fault) begin
                        r_d.out_valid    = 1'b1;
                        r_d.out_fault    = 1'b1;
                        r_d.out_cause    = pre_cause;
                        r_d.out_src_untr = 1'b1;
                        r_d.out_word     = '0;
                    end else begin
                        r_d.st                = ST_UNTR;
                        r_d.mem_got           = 1'b0;
                        r_d.perm_got          = 1'b0;
                        slot_start[PORT_MEM]  = 1'b1;
                        slot_start[PORT_PERM] = 1'b1;
                    end
                end
            end
            ST_UNTR: begin
                if (mem_rsp_valid && !r_q.mem_got) begin
                    r_d.mem_got = 1'b1;
                    r_d.dword   = mem_rsp_data;
                end
                if (perm_rsp_valid && !r_q.perm_got) begin
                    r_d.perm_got = 1'b1;
                    r_d.perm     = perm_rsp_bits;
                end
                if (mem_have && perm_have) begin
                    r_d.st           = ST_IDLE;
                    r_d.out_valid    = 1'b1;
                    r_d.out_fault    = res_fault;
                    r_d.out_cause    = res_cause;
                    r_d.out_src_untr = 1'b1;
                    r_d.out_word     = res_word;
                end
            end
            ST_TRUST: begin
                if (rom_rsp_valid) begin
                    r_d.st           = ST_IDLE;
                    r_d.out_valid    = 1'b1;
                    r_d.out_fault    = 1'b0;
                    r_d.out_cause    = '0;
                    r_d.out_src_untr = 1'b0;
                    r_d.out_word     = rom_rsp_data;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready      = (r_q.st == ST_IDLE);
    assign mem_req_valid  = slot_valid[PORT_MEM];
    assign perm_req_valid = slot_valid[PORT_PERM];
    assign rom_req_valid  = slot_valid[PORT_ROM];
    assign mem_req_addr   = {r_q.pc[PC_W-1:BYTE_SEL_W], {BYTE_SEL_W{1'b0}}};
    assign perm_req_page  = r_q.pc[PC_W-1:PAGE_SHIFT];
    assign rom_req_addr   = r_q.pc;
    assign out_valid      = r_q.out_valid;
    assign out_instr      = r_q.out_word;
    assign out_fault      = r_q.out_fault;
    assign out_cause      = r_q.out_cause;
    assign out_trusted    = r_q.out_valid & ~r_q.out_src_untr;
    assign out_untrusted  = r_q.out_valid & r_q.out_src_untr;

    wire [PAGE_W-1:0] unused_page_width_probe = perm_req_page;

endmodule

// File: rtl/ufetch_checker.sv
module ufetch_checker #(
    parameter int PC_W       = 48,
    parameter int GUARD_BITS = 16,
    parameter int INSTR_W    = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            untrusted_en,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_untrusted,
    input logic [PC_W-1:0] req_pc,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PC_W-1:0] mem_req_addr,
    input logic            perm_req_valid,
    input logic            rom_req_valid,
    input logic            out_valid,
    input logic [INSTR_W-1:0] out_instr,
    input logic            out_fault,
    input logic [1:0]      out_cause,
    input logic            out_trusted,
    input logic            out_untrusted
);

    logic take_untr, aligned, low_pc;

    assign take_untr = req_valid && req_ready && req_untrusted;
    assign aligned   = (req_pc[1:0] == 2'b00);
    assign low_pc    = (req_pc[PC_W-1:GUARD_BITS] == '0);

    AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        take_untr && !aligned |=> out_valid && out_fault && out_cause == 2'd0); // R1

    AST_LOWADDR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        take_untr && aligned && low_pc |=> out_valid && out_fault && out_cause == 2'd1); // R3

    AST_DISABLED_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        take_untr && aligned && !low_pc && !untrusted_en |=> out_valid && out_fault && out_cause == 2'd2); // R5

    AST_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        take_untr && !untrusted_en |=> !mem_req_valid && !perm_req_valid); // R10

    AST_SOURCE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req_valid |-> !mem_req_valid && !perm_req_valid); // R6

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fault |-> out_instr == '0 && out_untrusted && !out_trusted); // R11

endmodule

bind ufetch_top ufetch_checker #(
    .PC_W       (PC_W),
    .GUARD_BITS (GUARD_BITS),
    .INSTR_W    (INSTR_W)
) i_ufetch_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .untrusted_en   (untrusted_en),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_untrusted  (req_untrusted),
    .req_pc         (req_pc),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .perm_req_valid (perm_req_valid),
    .rom_req_valid  (rom_req_valid),
    .out_valid      (out_valid),
    .out_instr      (out_instr),
    .out_fault      (out_fault),
    .out_cause      (out_cause),
    .out_trusted    (out_trusted),
    .out_untrusted  (out_untrusted)
);

// File: tb/test_ufetch_top.sv
module test_ufetch_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, untrusted_en, req_valid, req_ready, req_untrusted;
    logic [47:0] req_pc;
    logic        rom_req_valid, rom_req_ready, rom_rsp_valid;
    logic [47:0] rom_req_addr;
    logic [31:0] rom_rsp_data;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [47:0] mem_req_addr;
    logic [63:0] mem_rsp_data;
    logic        perm_req_valid, perm_req_ready, perm_rsp_valid;
    logic [35:0] perm_req_page;
    logic [2:0]  perm_rsp_bits;
    logic        out_valid, out_fault, out_trusted, out_untrusted;
    logic [31:0] out_instr;
    logic [1:0]  out_cause;

    ufetch_top i_ufetch_top (.*);

    typedef struct {
        logic        fault;
        logic [1:0]  cause;
        logic [31:0] instr;
        bit          untr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    int cyc = 0, last_evt_cyc = 0;
    int mem_hs = 0, perm_hs = 0, rom_hs = 0;
    int mlat = 1, plat = 1, m_wait = 0, p_wait = 0, r_wait = 0;
    int m_cnt = 0, p_cnt = 0, r_cnt = 0;
    logic [63:0] mem_dw = '0;
    logic [2:0]  perm_v = '0;
    logic [47:0] exp_maddr = '0, exp_raddr = '0;
    logic [35:0] exp_page = '0;
    logic [31:0] rom_word = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder
    initial begin
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = mem_dw; last_evt_cyc = cyc;
                end
            end
            if (mem_req_valid) begin
                if (m_wait > 0) begin mem_req_ready = 1'b0; m_wait--; end
                else mem_req_ready = 1'b1;
            end else mem_req_ready = 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                mem_hs++; m_cnt = mlat;
                chk(mem_req_addr == exp_maddr, "R2 R9 mem address", 64'(mem_req_addr), 64'(exp_maddr));
            end
        end
    end

    // permission responder
    initial begin
        perm_req_ready = 1'b0; perm_rsp_valid = 1'b0; perm_rsp_bits = '0;
        forever begin
            @(negedge clk);
            perm_rsp_valid = 1'b0;
            if (p_cnt > 0) begin
                p_cnt--;
                if (p_cnt == 0) begin
                    perm_rsp_valid = 1'b1; perm_rsp_bits = perm_v; last_evt_cyc = cyc;
                end
            end
            if (perm_req_valid) begin
                if (p_wait > 0) begin perm_req_ready = 1'b0; p_wait--; end
                else perm_req_ready = 1'b1;
            end else perm_req_ready = 1'b0;
            if (perm_req_valid && perm_req_ready) begin
                perm_hs++; p_cnt = plat;
                chk(perm_req_page == exp_page, "R4 page number", 64'(perm_req_page), 64'(exp_page));
            end
        end
    end

    // ROM responder
    initial begin
        rom_req_ready = 1'b0; rom_rsp_valid = 1'b0; rom_rsp_data = '0;
        forever begin
            @(negedge clk);
            rom_rsp_valid = 1'b0;
            if (r_cnt > 0) begin
                r_cnt--;
                if (r_cnt == 0) begin
                    rom_rsp_valid = 1'b1; rom_rsp_data = rom_word; last_evt_cyc = cyc;
                end
            end
            if (rom_req_valid) begin
                if (r_wait > 0) begin rom_req_ready = 1'b0; r_wait--; end
                else rom_req_ready = 1'b1;
            end else rom_req_ready = 1'b0;
            if (rom_req_valid && rom_req_ready) begin
                rom_hs++; r_cnt = mlat;
                rom_word = rom_req_addr[31:0] ^ 32'hC0DE_0000;
                chk(rom_req_addr == exp_raddr, "R12 rom address", 64'(rom_req_addr), 64'(exp_raddr));
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8 unexpected result", 64'(out_instr), 64'(0));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(out_fault == e.fault, {e.tag, " fault flag"}, 64'(out_fault), 64'(e.fault));
                    if (e.fault)
                        chk(out_cause == e.cause, {e.tag, " cause"}, 64'(out_cause), 64'(e.cause));
                    chk(out_instr == e.instr, {e.tag, " R11 word"}, 64'(out_instr), 64'(e.instr));
                    chk(out_untrusted == e.untr && out_trusted == !e.untr, "R6 source tag",
                        64'({out_trusted, out_untrusted}), 64'({!e.untr, e.untr}));
                    chk(cyc == last_evt_cyc + 1, "R8 latency", 64'(cyc), 64'(last_evt_cyc + 1));
                end
            end else if (out_trusted || out_untrusted) begin
                chk(1'b0, "R6 idle source", 64'({out_trusted, out_untrusted}), 64'(0));
            end
        end
    end

    task automatic fetch(input logic [47:0] pc, input bit untr, input bit en_i,
                         input logic [63:0] dw, input logic [2:0] pv,
                         input int ml, input int pl, input int mw, input int pw);
        exp_t e;
        logic [31:0] w;
        int m0, p0, r0;
        bit pre;
        e.untr = untr; e.fault = 1'b0; e.cause = 2'd0; e.instr = '0;
        w = pc[2] ? dw[63:32] : dw[31:0];
        pre = 1'b0;
        if (!untr) begin
            e.instr = pc[31:0] ^ 32'hC0DE_0000; e.tag = "R12";
        end else if (pc[1:0] != 2'b00) begin
            e.fault = 1'b1; e.cause = 2'd0; e.tag = "R1"; pre = 1'b1;
        end else if (pc[47:16] == '0) begin
            e.fault = 1'b1; e.cause = 2'd1; e.tag = "R3"; pre = 1'b1;
        end else if (!en_i) begin
            e.fault = 1'b1; e.cause = 2'd2; e.tag = "R5"; pre = 1'b1;
        end else if (!pv[2]) begin
            e.fault = 1'b1; e.cause = 2'd2; e.tag = "R4";
        end else if (w == 32'h0000_0073) begin
            e.fault = 1'b1; e.cause = 2'd3; e.tag = "R7";
        end else begin
            e.instr = w; e.tag = "R2";
        end
        @(negedge clk);
        untrusted_en = en_i; mem_dw = dw; perm_v = pv;
        mlat = ml; plat = pl; m_wait = mw; p_wait = pw; r_wait = mw;
        exp_maddr = {pc[47:3], 3'b000}; exp_page = pc[47:12]; exp_raddr = pc;
        m0 = mem_hs; p0 = perm_hs; r0 = rom_hs;
        q.push_back(e);
        req_valid = 1'b1; req_pc = pc; req_untrusted = untr;
        while (!req_ready) @(negedge clk);
        last_evt_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        if (!untr) begin
            chk(mem_hs == m0 && perm_hs == p0 && rom_hs == r0 + 1, "R6 trusted port use",
                64'({mem_hs - m0, perm_hs - p0}), 64'(0));
        end else if (pre) begin
            chk(mem_hs == m0 && perm_hs == p0, "R10 no traffic on early fault",
                64'({mem_hs - m0, perm_hs - p0}), 64'(0));
        end else begin
            chk(mem_hs == m0 + 1 && perm_hs == p0 + 1 && rom_hs == r0, "R6 untrusted port use",
                64'({mem_hs - m0, perm_hs - p0}), 64'({32'd1, 32'd1}));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; untrusted_en = 1'b0; req_valid = 1'b0;
        req_untrusted = 1'b0; req_pc = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && out_valid == 1'b0, "R8 reset state",
            64'({req_ready, out_valid}), 64'(2'b10));
        chk(!mem_req_valid && !perm_req_valid && !rom_req_valid && !out_trusted && !out_untrusted,
            "R6 reset quiet", 64'({mem_req_valid, perm_req_valid, rom_req_valid}), 64'(0));

        // R12: trusted fetch, with and without the enable
        fetch(48'h0000_0001_2344, 1'b0, 1'b1, '0, 3'b000, 2, 1, 0, 0);
        fetch(48'h0000_0003_0010, 1'b0, 1'b0, '0, 3'b000, 3, 1, 2, 0);
        // R2: low half, both responses in the same cycle
        fetch(48'h0000_0001_0000, 1'b1, 1'b1, 64'h1234_5678_0badc0de, 3'b100, 1, 1, 0, 0);
        // R2: high half, memory later than permission
        fetch(48'h0000_0001_0004, 1'b1, 1'b1, 64'h1234_5678_0badc0de, 3'b101, 3, 1, 0, 0);
        // R8 R9: permission later, with back-pressure on both ports
        fetch(48'h0000_0002_3008, 1'b1, 1'b1, 64'hAAAA_5555_0000_1113, 3'b111, 1, 4, 2, 3);
        // R1: misaligned, and misaligned low address
        fetch(48'h0000_0001_0002, 1'b1, 1'b1, '0, 3'b100, 1, 1, 0, 0);
        fetch(48'h0000_0000_0001, 1'b1, 1'b1, '0, 3'b100, 1, 1, 0, 0);
        // R3: low address
        fetch(48'h0000_0000_FFF0, 1'b1, 1'b1, '0, 3'b100, 1, 1, 0, 0);
        // R5: enable clear
        fetch(48'h0000_0001_0000, 1'b1, 1'b0, 64'h0000_0000_0000_0013, 3'b100, 1, 1, 0, 0);
        // R4: page readable and writable only
        fetch(48'h0000_0001_0000, 1'b1, 1'b1, 64'h0000_0000_0000_0013, 3'b011, 2, 2, 0, 0);
        // R7: system call word, then together with no execute right
        fetch(48'h0000_0005_0000, 1'b1, 1'b1, 64'h0000_0013_0000_0073, 3'b100, 1, 2, 0, 0);
        fetch(48'h0000_0005_0004, 1'b1, 1'b1, 64'h0000_0073_0000_0013, 3'b100, 2, 1, 0, 0);
        fetch(48'h0000_0005_0000, 1'b1, 1'b1, 64'h0000_0013_0000_0073, 3'b001, 1, 1, 0, 0);
        // R2 R4: top page of the address space
        fetch(48'hFFFF_FFFF_F004, 1'b1, 1'b1, 64'hDEAD_BEEF_0000_0013, 3'b100, 2, 2, 1, 0);
        // back-to-back trusted and untrusted
        fetch(48'h0000_0007_0000, 1'b0, 1'b1, '0, 3'b000, 1, 1, 0, 0);
        fetch(48'h0000_0007_0000, 1'b1, 1'b1, 64'h0000_0000_00A0_0093, 3'b100, 1, 1, 0, 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule